// File: doc/BRIEF.md
# Triple-Redundant Accumulator Register with Voted Feedback and Output Gating

This block holds one accumulator value in three independent copies, called domains 0, 1 and 2. Each domain has its own clock, reset, control and data inputs, its own adder and its own state register. A domain does not load its next state from its own register alone. It forms the next state from the bitwise majority of all three registers, so a bit that flips in one copy is outvoted and repaired on the following clock edge.

Each domain also drives its value toward a shared output through its own enable. A minority check in each domain turns off that domain's enable while its value differs from the other two and those two agree. The merged output takes the value of an enabled domain, so a single faulty copy never reaches it. Each domain keeps a sticky flag that records that it dissented, and a per-domain synchronous clear resets that flag. Test inputs flip one selected state bit in one domain for one cycle, so upsets can be injected from the ports.

Top module: `tmr_acc_reg`

## Requirements
- R1: After reset, all three domain values are zero, all three output enables are 1 and all three error flags are 0.
- R2: On each clock edge where a domain's accumulate enable is 1, that domain loads the majority-voted state plus its addend, modulo 2^W. Where the enable is 0, it loads the voted state unchanged.
- R3: Majority feedback: one clock edge after a single domain's state is upset, and with no new upset applied, all three domain values are equal again and hold the correct value.
- R4: A domain's output enable is 0 exactly while its value differs from both other domains and those two agree. Otherwise it is 1.
- R5: The merged output equals the correct accumulator value whenever at most one domain is upset.
- R6: A domain's error flag is set on any clock edge where that domain dissents, and it stays set until that domain's clear is applied.
- R7: On an edge where a domain's clear is 1, its flag becomes 0, even if the domain dissents on that edge.
- R8: With a domain's flip request at 1 on an edge, that domain's stored value is its computed next state with bit `flip_bit` inverted. Bit 0 is the LSB. Any bit index from 0 to W-1 can be chosen.
- R9: A wrong input in one domain for one cycle, such as an accumulate enable that the other two do not share, does not change the merged output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 3 | Clock, one per domain |
| rst_ni | input | 3 | Asynchronous active-low reset, one per domain |
| acc_en_i | input | 3 | Accumulate enable, one per domain |
| addend_i | input | 3*W | Addend, W bits per domain, domain d at [d*W +: W] |
| flip_req_i | input | 3 | Test upset request, one per domain |
| flip_bit_i | input | 3*BW | Index of the bit to flip, BW bits per domain |
| flag_clr_i | input | 3 | Synchronous clear of the error flag, one per domain |
| dom_val_o | output | 3*W | Each domain's state value |
| dom_oe_o | output | 3 | Each domain's output enable from its minority check |
| merged_o | output | W | Merged output of the enabled paths |
| err_flag_o | output | 3 | Sticky dissent flag, one per domain |

## Verification
A dissenting domain exists for only one cycle before the voted feedback repairs it. The bench therefore drives the flip requests and the per-domain inputs on the falling edge and samples in the cycle right after the upset. In that window it checks the enables, the merged value and the raw copy, and one cycle later it checks the repair and the flag. To test the priority of clear over set, a clear has to arrive on the one edge where a dissent exists. The bench holds a domain's clear across exactly the edge that follows its injected upset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NDOM = 3;

  function automatic logic [63:0] maj3(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_na,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_na) begin
    if (!rst_na) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_minority.sv
module tmr_minority #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] peer_a,
  input  logic [W-1:0] peer_b,
  output logic         dissent
);
  always_comb begin
    dissent = (own != peer_a) && (own != peer_b) && (peer_a == peer_b);
  end
endmodule

// File: rtl/tmr_domain.sv
module tmr_domain
  import tmr_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned BW  = 3,
  parameter int unsigned IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [W-1:0]    addend,
  input  logic            flip_req,
  input  logic [BW-1:0]   flip_bit,
  input  logic            flag_clr,
  input  logic [3*W-1:0]  all_st,
  output logic [W-1:0]    st_o,
  output logic            oe_o,
  output logic            flag_o
);
  localparam int unsigned PA = (IDX + 1) % 3;
  localparam int unsigned PB = (IDX + 2) % 3;

  logic [W-1:0] st_q, st_d, voted, flip_mask;
  logic         flag_q, flag_d, dissent;
  logic [63:0]  maj_w;

  always_comb begin
    maj_w     = maj3(64'(all_st[0 +: W]), 64'(all_st[W +: W]), 64'(all_st[2*W +: W]));
    voted     = maj_w[W-1:0];
    flip_mask = flip_req ? (W'(1) << flip_bit) : '0;
    st_d      = (en ? (voted + addend) : voted) ^ flip_mask;
  end

  tmr_minority #(.W(W)) minority_i (
    .own    (all_st[IDX*W +: W]),
    .peer_a (all_st[PA*W +: W]),
    .peer_b (all_st[PB*W +: W]),
    .dissent(dissent)
  );

  always_comb begin
    if (flag_clr)     flag_d = 1'b0;
    else if (dissent) flag_d = 1'b1;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  assign st_o   = st_q;
  assign oe_o   = ~dissent;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_acc_reg.sv
module tmr_acc_reg
  import tmr_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [2:0]      clk_i,
  input  logic [2:0]      rst_ni,
  input  logic [2:0]      acc_en_i,
  input  logic [3*W-1:0]  addend_i,
  input  logic [2:0]      flip_req_i,
  input  logic [3*BW-1:0] flip_bit_i,
  input  logic [2:0]      flag_clr_i,
  output logic [3*W-1:0]  dom_val_o,
  output logic [2:0]      dom_oe_o,
  output logic [W-1:0]    merged_o,
  output logic [2:0]      err_flag_o
);
  logic [3*W-1:0] st_all;
  logic [2:0]     rst_s;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    tmr_rst_sync #(.STAGES(2)) rsync_i (
      .clk   (clk_i[d]),
      .rst_na(rst_ni[d]),
      .rst_ns(rst_s[d])
    );

    tmr_domain #(.W(W), .BW(BW), .IDX(d)) dom_i (
      .clk     (clk_i[d]),
      .rst_n   (rst_s[d]),
      .en      (acc_en_i[d]),
      .addend  (addend_i[d*W +: W]),
      .flip_req(flip_req_i[d]),
      .flip_bit(flip_bit_i[d*BW +: BW]),
      .flag_clr(flag_clr_i[d]),
      .all_st  (st_all),
      .st_o    (st_all[d*W +: W]),
      .oe_o    (dom_oe_o[d]),
      .flag_o  (err_flag_o[d])
    );
  end

  always_comb begin
    if (dom_oe_o[0])      merged_o = st_all[0 +: W];
    else if (dom_oe_o[1]) merged_o = st_all[W +: W];
    else                  merged_o = st_all[2*W +: W];
  end

  assign dom_val_o = st_all;
endmodule

// File: rtl/tmr_acc_reg_chk.sv
module tmr_acc_reg_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned BW = 3
) (
  input logic [2:0]      clk_i,
  input logic [2:0]      rst_ni,
  input logic [2:0]      acc_en_i,
  input logic [3*W-1:0]  addend_i,
  input logic [2:0]      flip_req_i,
  input logic [2:0]      flag_clr_i,
  input logic [3*W-1:0]  dom_val_o,
  input logic [2:0]      dom_oe_o,
  input logic [W-1:0]    merged_o,
  input logic [2:0]      err_flag_o
);
  logic [W-1:0] v0, v1, v2, vmaj;
  logic         all_rst;
  assign v0      = dom_val_o[0 +: W];
  assign v1      = dom_val_o[W +: W];
  assign v2      = dom_val_o[2*W +: W];
  assign vmaj    = (v0 & v1) | (v1 & v2) | (v0 & v2);
  assign all_rst = &rst_ni;

  // R5: merged output follows the bitwise majority of the copies
  assert_merged_majority_R5: assert property (@(posedge clk_i[0]) disable iff (!all_rst)
    merged_o == vmaj);

  // R3: a dissent with no new upset or input skew is repaired by the next edge
  assert_repair_next_edge_R3: assert property (@(posedge clk_i[0]) disable iff (!all_rst)
    (!(&dom_oe_o) && (flip_req_i == 3'b000) && (acc_en_i == 3'b000)) |=> (&dom_oe_o));

  for (genvar d = 0; d < 3; d++) begin : g_flag
    // R6: flag set by dissent unless cleared
    assert_flag_set_R6: assert property (@(posedge clk_i[0]) disable iff (!all_rst)
      (!dom_oe_o[d] && !flag_clr_i[d]) |=> err_flag_o[d]);
    // R6: flag is sticky
    assert_flag_sticky_R6: assert property (@(posedge clk_i[0]) disable iff (!all_rst)
      (err_flag_o[d] && !flag_clr_i[d]) |=> err_flag_o[d]);
    // R7: clear wins
    assert_flag_clear_R7: assert property (@(posedge clk_i[0]) disable iff (!all_rst)
      flag_clr_i[d] |=> !err_flag_o[d]);
  end
endmodule

bind tmr_acc_reg tmr_acc_reg_chk #(.W(W), .BW(BW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .addend_i(addend_i),
  .flip_req_i(flip_req_i), .flag_clr_i(flag_clr_i), .dom_val_o(dom_val_o),
  .dom_oe_o(dom_oe_o), .merged_o(merged_o), .err_flag_o(err_flag_o)
);

// File: tb/tmr_acc_reg_tb_top.sv
module tmr_acc_reg_tb_top;
  localparam int W  = 8;
  localparam int BW = 3;
  localparam int NV = 6;
  // {en, addend, expected accumulator after the edge}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'd5,   8'd5},  {1'b1, 8'd10, 8'd15}, {1'b0, 8'd99, 8'd15},
    {1'b1, 8'd250, 8'd9},  {1'b1, 8'd1,  8'd10}, {1'b1, 8'd0,  8'd10}};

  logic clk = 1'b0;
  logic [2:0] rst_ni, acc_en_i, flip_req_i, flag_clr_i, dom_oe_o, err_flag_o;
  logic [3*W-1:0] addend_i, dom_val_o;
  logic [3*BW-1:0] flip_bit_i;
  logic [W-1:0] merged_o;
  int total = 0, bad = 0;
  logic [W-1:0] acc;

  always #5 clk = ~clk;

  tmr_acc_reg #(.W(W), .BW(BW)) dut_i (
    .clk_i({3{clk}}), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .addend_i(addend_i),
    .flip_req_i(flip_req_i), .flip_bit_i(flip_bit_i), .flag_clr_i(flag_clr_i),
    .dom_val_o(dom_val_o), .dom_oe_o(dom_oe_o), .merged_o(merged_o),
    .err_flag_o(err_flag_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    acc_en_i = '0; addend_i = '0; flip_req_i = '0; flip_bit_i = '0; flag_clr_i = '0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_ni = '0;
    repeat (3) @(negedge clk);
    rst_ni = 3'b111;
    repeat (4) step();
    // R1 reset state
    chk("R1 values", 32'(dom_val_o), 32'h0);
    chk("R1 enables", 32'(dom_oe_o), 32'h7);
    chk("R1 flags", 32'(err_flag_o), 32'h0);

    // R2 table walk, all domains identical
    for (int i = 0; i < NV; i++) begin
      acc_en_i = {3{VEC[i][16]}};
      addend_i = {3{VEC[i][15:8]}};
      step();
      chk("R2 merged", 32'(merged_o), 32'(VEC[i][7:0]));
      chk("R2 copies", 32'(dom_val_o), 32'({3{VEC[i][7:0]}}));
    end
    idle();
    acc = 8'd10;

    // R8/R4/R5: upset bit 3 of domain 1
    flip_req_i = 3'b010; flip_bit_i = 9'(3) << BW;
    step();
    chk("R8 flipped copy", 32'(dom_val_o[W +: W]), 32'(acc ^ 8'h08));
    chk("R4 enable gated", 32'(dom_oe_o), 32'h5);
    chk("R5 merged masked", 32'(merged_o), 32'(acc));
    idle();
    step();
    // R3 repair, R6 flag
    chk("R3 repaired", 32'(dom_val_o), 32'({3{acc}}));
    chk("R4 enables back", 32'(dom_oe_o), 32'h7);
    chk("R6 flag set", 32'(err_flag_o), 32'h2);
    step();
    chk("R6 flag sticky", 32'(err_flag_o), 32'h2);
    flag_clr_i = 3'b010;
    step();
    flag_clr_i = '0;
    chk("R6 flag cleared", 32'(err_flag_o), 32'h0);

    // R8 MSB upset in domain 0 while accumulating
    acc_en_i = 3'b111; addend_i = {3{8'd3}};
    flip_req_i = 3'b001; flip_bit_i = 9'(7);
    step();
    acc = acc + 8'd3;
    chk("R8 msb flip", 32'(dom_val_o[0 +: W]), 32'(acc ^ 8'h80));
    chk("R5 merged under accumulate", 32'(merged_o), 32'(acc));
    chk("R4 domain0 gated", 32'(dom_oe_o), 32'h6);
    idle();
    step();
    chk("R3 repaired msb", 32'(dom_val_o), 32'({3{acc}}));
    flag_clr_i = 3'b001;
    step();
    idle();

    // R7 clear on the dissent edge for domain 2
    flip_req_i = 3'b100; flip_bit_i = 9'(0) << (2*BW);
    step();
    flip_req_i = '0;
    chk("R4 domain2 gated", 32'(dom_oe_o), 32'h3);
    flag_clr_i = 3'b100;
    step();
    flag_clr_i = '0;
    chk("R7 clear wins", 32'(err_flag_o), 32'h0);

    // R9 input skew in domain 0 only
    acc_en_i = 3'b001; addend_i = {8'd0, 8'd0, 8'd7};
    step();
    idle();
    chk("R9 merged unaffected", 32'(merged_o), 32'(acc));
    chk("R9 skew gated", 32'(dom_oe_o), 32'h6);
    step();
    chk("R9 repaired", 32'(dom_val_o), 32'({3{acc}}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule